// File: doc/BRIEF.md
# SPI FIFO Interrupt and DMA Request Logic

This block sits beside the transmit and receive FIFOs of an SPI controller and turns their fill levels and push/pop strobes into a status vector, a set of raw and masked interrupt sources, one combined interrupt line, and the two DMA request lines. It holds no FIFO storage and no bus interface; the register file around it supplies the thresholds, watermarks, mask, clear strobe and DMA enables, and reads back the vectors it produces.

Level-based sources (transmit low, receive high) follow the FIFO levels each cycle against thresholds latched while the controller is disabled. Error sources (transmit overflow, receive overflow, receive underflow) and the chip-select-inactive event are sticky and are removed by a write-one clear that can target each source or all of them. DMA requests use their own watermarks, separate from the interrupt thresholds. The FIFO depth is a parameter (32 or 64).

Top module: `spi_fifo_irq_ctl`

## Requirements
- R1: The status vector reports busy at bit 0, transmit FIFO full (level equals depth) at bit 1, transmit FIFO empty at bit 2, receive FIFO empty at bit 3, receive FIFO full at bit 4 and target transmit busy at bit 5.
- R2: Raw interrupt bit 0 (transmit low) is high whenever the transmit level is less than or equal to the latched transmit threshold.
- R3: Raw interrupt bit 4 (receive high) is high when the receive level is strictly greater than the latched receive threshold, so a threshold of N fires at N+1 words.
- R4: Raw interrupt bit 1 (transmit overflow) sets in the cycle after a transmit push while the transmit level equals the depth, and stays set until cleared; a push below full does not set it.
- R5: Raw interrupt bit 3 (receive overflow) sets after a receive push at full level and raw bit 2 (receive underflow) sets after a receive pop at level zero; both are sticky.
- R6: A clear strobe with clear bit 1 removes receive underflow, bit 2 removes receive overflow, bit 3 removes transmit overflow and bit 0 removes every sticky source including chip-select inactive; a new set event in the same cycle wins over the clear.
- R7: Raw interrupt bit 6 sets after a chip-select-inactive pulse and is sticky; raw bit 5 is always zero.
- R8: The masked vector is the raw vector AND the mask, and the interrupt line is high exactly when any masked bit is high; a zero mask silences everything.
- R9: The receive DMA request is high when the controller is enabled, DMA enable bit 0 is set and the receive level is at least the receive watermark plus one.
- R10: The transmit DMA request is high when the controller is enabled, DMA enable bit 1 is set and the transmit level is at or below the transmit watermark.
- R11: Thresholds and watermarks are captured only on clock edges where the controller is disabled; changes applied while enabled have no effect until it is next disabled.
- R12: While the controller is disabled both DMA requests are low regardless of levels and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enabled |
| busy_in | input | 1 | Shift engine busy |
| tgt_tx_busy_in | input | 1 | Target-mode transmit busy |
| tx_level | input | LW | Transmit FIFO fill level |
| rx_level | input | LW | Receive FIFO fill level |
| tx_push | input | 1 | Transmit FIFO write strobe |
| rx_push | input | 1 | Receive FIFO write strobe from the shifter |
| rx_pop | input | 1 | Receive FIFO read strobe |
| cs_gone | input | 1 | Chip-select went inactive (pulse) |
| tx_thr | input | LW | Transmit low threshold |
| rx_thr | input | LW | Receive high threshold |
| tx_wm | input | LW | Transmit DMA watermark |
| rx_wm | input | LW | Receive DMA watermark |
| irq_mask | input | 7 | Interrupt mask |
| clr_wr | input | 1 | Clear strobe |
| clr_bits | input | 4 | Clear selection |
| dma_en | input | 2 | DMA enables (bit 0 receive, bit 1 transmit) |
| status | output | 6 | Status vector |
| raw_irq | output | 7 | Raw interrupt vector |
| masked_irq | output | 7 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench targets the off-by-one edges: a receive threshold of N probed at exactly N and N+1 words, the transmit threshold and watermark probed at equality and one above, and the receive watermark at its value and one more; a design using the wrong comparison fires one word early or late. It pushes into a FIFO one below full to show overflow is not set early, applies each clear bit alone to expose a clear that wipes the wrong source, and collides a set event with its clear to catch a lost error. It also changes a threshold while enabled, which a design without capture-on-disable would obey at once, and checks that disabling drops both DMA requests.

// File: rtl/spi_fifo_irq_ctl.sv
module spi_fifo_irq_ctl #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          busy_in,
  input  logic          tgt_tx_busy_in,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_push,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          cs_gone,
  input  logic [LW-1:0] tx_thr,
  input  logic [LW-1:0] rx_thr,
  input  logic [LW-1:0] tx_wm,
  input  logic [LW-1:0] rx_wm,
  input  logic [6:0]    irq_mask,
  input  logic          clr_wr,
  input  logic [3:0]    clr_bits,
  input  logic [1:0]    dma_en,
  output logic [5:0]    status,
  output logic [6:0]    raw_irq,
  output logic [6:0]    masked_irq,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] tx_thr_q, rx_thr_q, tx_wm_q, rx_wm_q;
  logic tx_ovf_q, rx_ovf_q, rx_udf_q, cs_q;

  wire tx_full  = (tx_level == FULL);
  wire rx_full  = (rx_level == FULL);
  wire tx_empty = (tx_level == '0);
  wire rx_empty = (rx_level == '0);

  wire tx_ovf_set = tx_push & tx_full;
  wire rx_ovf_set = rx_push & rx_full;
  wire rx_udf_set = rx_pop & rx_empty;

  wire clr_all = clr_wr & clr_bits[0];
  wire clr_udf = clr_all | (clr_wr & clr_bits[1]);
  wire clr_rov = clr_all | (clr_wr & clr_bits[2]);
  wire clr_tov = clr_all | (clr_wr & clr_bits[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      tx_wm_q  <= '0;
      rx_wm_q  <= '0;
    end else if (!enable) begin
      tx_thr_q <= tx_thr;
      rx_thr_q <= rx_thr;
      tx_wm_q  <= tx_wm;
      rx_wm_q  <= rx_wm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
      rx_udf_q <= 1'b0;
      cs_q     <= 1'b0;
    end else begin
      tx_ovf_q <= tx_ovf_set | (tx_ovf_q & ~clr_tov);
      rx_ovf_q <= rx_ovf_set | (rx_ovf_q & ~clr_rov);
      rx_udf_q <= rx_udf_set | (rx_udf_q & ~clr_udf);
      cs_q     <= cs_gone    | (cs_q & ~clr_all);
    end
  end

  assign status = {tgt_tx_busy_in, rx_full, rx_empty, tx_empty, tx_full, busy_in};

  assign raw_irq = {cs_q, 1'b0, (rx_level > rx_thr_q), rx_ovf_q, rx_udf_q,
                    tx_ovf_q, (tx_level <= tx_thr_q)};
  assign masked_irq = raw_irq & irq_mask;
  assign irq        = |masked_irq;

  assign rx_dma_req = enable & dma_en[0] & (rx_level > rx_wm_q);
  assign tx_dma_req = enable & dma_en[1] & (tx_level <= tx_wm_q);

  // R4
  tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_level == FULL) |=> raw_irq[1]);

  // R4
  tx_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_irq[1] && !(clr_wr && (clr_bits[0] || clr_bits[3]))) |=> raw_irq[1]);

  // R5
  rx_udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_level == '0) |=> raw_irq[2]);

  // R6
  tov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[3] && !(tx_push && tx_level == FULL)) |=> !raw_irq[1]);

  // R7
  cs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_gone |=> raw_irq[6]);

  // R8
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

  // R12
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!tx_dma_req && !rx_dma_req));

  // R11
  thr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> ($stable(rx_thr_q) && $stable(tx_thr_q)));
endmodule

// File: tb/sim_spi_fifo_irq_ctl.sv
module sim_spi_fifo_irq_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, busy_in = 1'b0, tgt_tx_busy_in = 1'b0;
  logic [LW-1:0] tx_level = '0, rx_level = '0, tx_thr = '0, rx_thr = '0, tx_wm = '0, rx_wm = '0;
  logic tx_push = 1'b0, rx_push = 1'b0, rx_pop = 1'b0, cs_gone = 1'b0, clr_wr = 1'b0;
  logic [6:0] irq_mask = '0;
  logic [3:0] clr_bits = '0;
  logic [1:0] dma_en = '0;
  logic [5:0] status;
  logic [6:0] raw_irq, masked_irq;
  logic irq, tx_dma_req, rx_dma_req;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_irq_ctl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .busy_in(busy_in),
    .tgt_tx_busy_in(tgt_tx_busy_in), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop), .cs_gone(cs_gone),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_wm(tx_wm), .rx_wm(rx_wm),
    .irq_mask(irq_mask), .clr_wr(clr_wr), .clr_bits(clr_bits), .dma_en(dma_en),
    .status(status), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_bits = 4'b0001; tick();
    clr_wr = 1'b0; clr_bits = '0;
  endtask

  task automatic t_reset();
    chk("R1 reset status", 32'(status), 32'h0C);
    chk("R2 reset raw", 32'(raw_irq), 32'h01);
    chk("R8 reset irq", 32'(irq), 0);
    chk("R12 reset dma", 32'({tx_dma_req, rx_dma_req}), 0);
  endtask

  task automatic t_status();
    busy_in = 1'b1; tgt_tx_busy_in = 1'b1; tx_level = LW'(DEPTH); rx_level = LW'(DEPTH);
    #1 chk("R1 all full", 32'(status), 32'h33);
    busy_in = 1'b0; tgt_tx_busy_in = 1'b0; tx_level = 0; rx_level = 5;
    #1 chk("R1 tx empty rx partial", 32'(status), 32'h04);
    rx_level = 0;
  endtask

  task automatic t_rx_thr();
    enable = 1'b0; rx_thr = 5; tick(); enable = 1'b1;
    rx_level = 5; #1 chk("R3 at N", 32'(raw_irq[4]), 0);
    rx_level = 6; #1 chk("R3 at N+1", 32'(raw_irq[4]), 1);
  endtask

  task automatic t_tx_thr();
    enable = 1'b0; tx_thr = 4; tick(); enable = 1'b1;
    tx_level = 4; #1 chk("R2 at thr", 32'(raw_irq[0]), 1);
    tx_level = 5; #1 chk("R2 above thr", 32'(raw_irq[0]), 0);
  endtask

  task automatic t_freeze();
    rx_thr = 20; tick();
    rx_level = 6; #1 chk("R11 change ignored while enabled", 32'(raw_irq[4]), 1);
    enable = 1'b0; tick();
    chk("R11 captured when disabled", 32'(raw_irq[4]), 0);
    rx_level = 0;
  endtask

  task automatic t_tx_ovf();
    clear_all();
    tx_level = LW'(DEPTH - 1); tx_push = 1'b1; tick(); tx_push = 1'b0;
    chk("R4 push below full", 32'(raw_irq[1]), 0);
    tx_level = LW'(DEPTH); tx_push = 1'b1; tick(); tx_push = 1'b0;
    chk("R4 push at full", 32'(raw_irq[1]), 1);
    tx_level = 10; tick(); tick();
    chk("R4 sticky", 32'(raw_irq[1]), 1);
  endtask

  task automatic set_errors();
    tx_level = LW'(DEPTH); tx_push = 1'b1;
    rx_level = LW'(DEPTH); rx_push = 1'b1;
    tick();
    tx_push = 1'b0; rx_push = 1'b0; rx_level = 0; rx_pop = 1'b1; cs_gone = 1'b1;
    tick();
    rx_pop = 1'b0; cs_gone = 1'b0; tx_level = 10;
  endtask

  task automatic t_clear();
    clear_all();
    set_errors();
    chk("R5 rx ovf and udf set", 32'(raw_irq[3:1]), 32'h7);
    clr_wr = 1'b1; clr_bits = 4'b0010; tick(); clr_wr = 1'b0;
    chk("R6 clear udf only", 32'(raw_irq[3:1]), 32'h5);
    clr_wr = 1'b1; clr_bits = 4'b1000; tick(); clr_wr = 1'b0;
    chk("R6 clear tx ovf only", 32'(raw_irq[3:1]), 32'h4);
    clr_wr = 1'b1; clr_bits = 4'b0100; tick(); clr_wr = 1'b0;
    chk("R6 clear rx ovf only", 32'({raw_irq[6], raw_irq[3:1]}), 32'h8);
    set_errors();
    clr_wr = 1'b1; clr_bits = 4'b0001; tick(); clr_wr = 1'b0;
    chk("R6 clear all", 32'({raw_irq[6], raw_irq[3:1]}), 0);
    tx_level = LW'(DEPTH); tx_push = 1'b1; clr_wr = 1'b1; clr_bits = 4'b1000; tick();
    tx_push = 1'b0; clr_wr = 1'b0; clr_bits = '0; tx_level = 10;
    chk("R6 set wins over clear", 32'(raw_irq[1]), 1);
  endtask

  task automatic t_cs_mask();
    clear_all();
    tx_level = 20; rx_level = 0;
    cs_gone = 1'b1; tick(); cs_gone = 1'b0; tick();
    chk("R7 cs inactive sticky", 32'(raw_irq), 32'h40);
    irq_mask = 7'h00; #1 chk("R8 zero mask", 32'({irq, masked_irq}), 0);
    irq_mask = 7'h3F; #1 chk("R8 mask excludes bit6", 32'({irq, masked_irq}), 0);
    irq_mask = 7'h40; #1 chk("R8 mask passes bit6", 32'({irq, masked_irq}), 32'hC0);
    irq_mask = 7'h00;
  endtask

  task automatic t_dma();
    enable = 1'b0; rx_wm = 3; tx_wm = 8; tick(); enable = 1'b1;
    dma_en = 2'b01; tx_level = 0;
    rx_level = 3; #1 chk("R9 below wm+1", 32'(rx_dma_req), 0);
    rx_level = 4; #1 chk("R9 at wm+1", 32'(rx_dma_req), 1);
    chk("R10 tx disabled by enable bit", 32'(tx_dma_req), 0);
    dma_en = 2'b10;
    #1 chk("R9 rx disabled by enable bit", 32'(rx_dma_req), 0);
    tx_level = 8; #1 chk("R10 at wm", 32'(tx_dma_req), 1);
    tx_level = 9; #1 chk("R10 above wm", 32'(tx_dma_req), 0);
    dma_en = 2'b11; tx_level = 2; rx_level = 10;
    #1 chk("R10 R9 both enabled", 32'({tx_dma_req, rx_dma_req}), 3);
    enable = 1'b0; #1 chk("R12 disabled blocks dma", 32'({tx_dma_req, rx_dma_req}), 0);
    dma_en = 2'b00; rx_level = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_status();
    t_rx_thr();
    t_tx_thr();
    t_freeze();
    t_tx_ovf();
    t_clear();
    t_cs_mask();
    t_dma();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule